// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of devices and presents a single interrupt line to a processor core. Each device line has a fixed priority, which is set by a parameter. The controller first picks the most urgent pending request. It then compares that request with the level now in service and raises the core interrupt only when the candidate is strictly more urgent. One extra edge-sensitive input acts as a non-maskable request. It outranks every device and is not held back by the in-service level.

When the core acknowledges, the controller strobes an acknowledge to the chosen device. It then waits for that device to place a vector on the shared vector bus, and hands the vector to the core as a one-cycle pulse. If no vector arrives within a bounded number of cycles, a sticky timeout flag is raised instead and the pending service is withdrawn. The controller keeps the levels in service on a small stack. Each acknowledge pushes a level and each end-of-service input pops one, so a nested handler returns to the level it interrupted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `core_irq`, `src_ack`, `vec_valid` and `vec_timeout` are low and no level is in service.
- R2: Device i has priority field `SRC_PRIO[i*PRIO_W +: PRIO_W]`, and a larger value is more urgent. Among requests of the same priority, the lowest device index wins.
- R3: `core_irq` rises only when the winning request is strictly more urgent than the level in service. A request of equal or lower urgency waits.
- R4: A rising edge on `nmi_req` is latched. It beats every device and is presented even while another level is in service. It is acknowledged on `src_ack` bit `NUM_SRC`.
- R5: When `core_ack` is seen while `core_irq` is high, `src_ack` shows the winner one-hot in the next cycle, for exactly one cycle, and `core_irq` drops.
- R6: The first cycle with `dev_vec_valid` after an acknowledge captures `dev_vec`. The captured value appears on `vec_out`, with `vec_valid` high for exactly one cycle, in the following cycle.
- R7: If no vector arrives within `TIMEOUT_CYC` cycles after the acknowledge, `vec_timeout` is set and the level pushed for that service is removed. The flag stays set until `timeout_clr` is pulsed.
- R8: A `svc_done` pulse pops the in-service level. A request that was masked by the popped level is then presented.
- R9: While `STACK_DEPTH` levels are in service, `core_irq` stays low whatever is requested.
- R10: A `core_ack` while `core_irq` is low produces no device acknowledge and pushes no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level-sensitive device requests |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive |
| core_irq | output | 1 | Interrupt to the core |
| core_ack | input | 1 | Core acknowledge |
| src_ack | output | NUM_SRC+1 | One-hot acknowledge to the winning device (top bit: non-maskable source) |
| dev_vec | input | VEC_W | Vector bus from the devices |
| dev_vec_valid | input | 1 | Vector bus qualifier |
| vec_out | output | VEC_W | Vector delivered to the core |
| vec_valid | output | 1 | One-cycle pulse marking `vec_out` |
| svc_done | input | 1 | End-of-service from the core |
| vec_timeout | output | 1 | Sticky flag: no vector arrived in time |
| timeout_clr | input | 1 | Clears `vec_timeout` |

## Verification
The bench builds the controller with four devices, two-bit priorities of 1, 3, 1 and 2, a stack depth of two and a sixteen-cycle timeout. This shallow stack lets a single nesting fill the stack, which exercises the full-stack block, the release after a pop, and a non-maskable request nested over the top device level. The duplicated priority value exposes the lowest-index tie rule, and the short timeout lets the exact expiry cycle be checked on both sides.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_VEC  = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/prio_irq_pick.sv
// Combinational winner selection: strict compare keeps the lowest index on ties,
// then the latched non-maskable request overrides everything.
module prio_irq_pick #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  parameter int IDX_W   = 4,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = '0
) (
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               nmi_pend,
  output logic [LVL_W-1:0]   best_lvl,
  output logic [IDX_W-1:0]   best_idx,
  output logic               best_any
);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'((1 << PRIO_W) + 1);

  logic [LVL_W-1:0] src_lvl [NUM_SRC];

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_lvl
      assign src_lvl[g] = LVL_W'(SRC_PRIO[g*PRIO_W +: PRIO_W]) + LVL_W'(1);
    end
  endgenerate

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    best_any = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_req[i] && (src_lvl[i] > best_lvl)) begin
        best_lvl = src_lvl[i];
        best_idx = IDX_W'(i);
        best_any = 1'b1;
      end
    end
    if (nmi_pend) begin
      best_lvl = NMI_LVL;
      best_idx = IDX_W'(NUM_SRC);
      best_any = 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
// In-service level stack. Empty reads as level 0. Push and pop together replace the top.
module prio_irq_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] top_lvl,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] top_ptr;
  logic [PTR_W-1:0] nxt_ptr;
  logic             empty;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign top_ptr = PTR_W'(cnt - CNT_W'(1));
  assign nxt_ptr = PTR_W'(cnt);
  assign top_lvl = empty ? '0 : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (push && pop && !empty) begin
      mem[top_ptr] <= push_lvl;
    end else if (push && !full) begin
      mem[nxt_ptr] <= push_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && pop && !empty) begin
      cnt <= cnt;
    end else if (push && !full) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/prio_irq_timer.sv
// Counts cycles while run is high. expired marks the LIMIT-th cycle of waiting.
module prio_irq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 8,
  parameter int STACK_DEPTH = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = 24'hFAC688
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               nmi_req,
  output logic               core_irq,
  input  logic               core_ack,
  output logic [NUM_SRC:0]   src_ack,
  input  logic [VEC_W-1:0]   dev_vec,
  input  logic               dev_vec_valid,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  input  logic               svc_done,
  output logic               vec_timeout,
  input  logic               timeout_clr
);
  localparam int LVL_W = PRIO_W + 1;
  localparam int IDX_W = $clog2(NUM_SRC + 1);
  localparam int ACK_W = NUM_SRC + 1;

  ctl_state_t       state;
  logic             nmi_q;
  logic             nmi_pend;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             best_any;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] cur_lvl;
  logic             svc_full;
  logic             take;
  logic             grant;
  logic             expired;
  logic             abandon;
  logic             svc_pop;

  prio_irq_pick #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .LVL_W   (LVL_W),
    .IDX_W   (IDX_W),
    .SRC_PRIO(SRC_PRIO)
  ) u_pick (
    .src_req (src_req),
    .nmi_pend(nmi_pend),
    .best_lvl(best_lvl),
    .best_idx(best_idx),
    .best_any(best_any)
  );

  prio_irq_stack #(
    .DEPTH(STACK_DEPTH),
    .LVL_W(LVL_W)
  ) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (grant),
    .pop     (svc_pop),
    .push_lvl(win_lvl),
    .top_lvl (cur_lvl),
    .full    (svc_full)
  );

  prio_irq_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (state == ST_VEC),
    .expired(expired)
  );

  assign take    = best_any && (best_lvl > cur_lvl) && !svc_full;
  assign grant   = (state == ST_REQ) && core_ack;
  assign abandon = (state == ST_VEC) && !dev_vec_valid && expired;
  assign svc_pop = svc_done || abandon;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_req;
      if (nmi_req && !nmi_q) begin
        nmi_pend <= 1'b1;
      end else if (grant && (win_idx == IDX_W'(NUM_SRC))) begin
        nmi_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_timeout <= 1'b0;
    end else if (abandon) begin
      vec_timeout <= 1'b1;
    end else if (timeout_clr) begin
      vec_timeout <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      core_irq  <= 1'b0;
      src_ack   <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      win_lvl   <= '0;
      win_idx   <= '0;
    end else begin
      src_ack   <= '0;
      vec_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            win_lvl  <= best_lvl;
            win_idx  <= best_idx;
            core_irq <= 1'b1;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (core_ack) begin
            src_ack  <= ACK_W'(1) << win_idx;
            core_irq <= 1'b0;
            state    <= ST_VEC;
          end else if (take) begin
            win_lvl <= best_lvl;
            win_idx <= best_idx;
          end else begin
            core_irq <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_VEC: begin
          if (dev_vec_valid) begin
            vec_out   <= dev_vec;
            vec_valid <= 1'b1;
            state     <= ST_IDLE;
          end else if (expired) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int ACK_W = 9,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             core_irq,
  input logic             core_ack,
  input logic [ACK_W-1:0] src_ack,
  input logic             vec_valid,
  input logic             vec_timeout,
  input logic             timeout_clr,
  input logic             svc_full,
  input logic [LVL_W-1:0] win_lvl,
  input logic [LVL_W-1:0] cur_lvl
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ack));

  assert_ack_after_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (src_ack != '0) |-> $past(core_irq && core_ack));

  assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_timeout && !timeout_clr) |=> vec_timeout);

  assert_irq_above_level_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(core_irq) |-> (win_lvl > $past(cur_lvl)));

  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(core_irq) |-> !$past(svc_full));

  assert_idle_ack_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (core_ack && !core_irq) |=> (src_ack == '0));
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .ACK_W(NUM_SRC + 1),
  .LVL_W(PRIO_W + 1)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_irq   (core_irq),
  .core_ack   (core_ack),
  .src_ack    (src_ack),
  .vec_valid  (vec_valid),
  .vec_timeout(vec_timeout),
  .timeout_clr(timeout_clr),
  .svc_full   (svc_full),
  .win_lvl    (win_lvl),
  .cur_lvl    (cur_lvl)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_req = '0;
  logic          nmi_req = 1'b0;
  logic          core_irq;
  logic          core_ack = 1'b0;
  logic [NS:0]   src_ack;
  logic [7:0]    dev_vec = '0;
  logic          dev_vec_valid = 1'b0;
  logic [7:0]    vec_out;
  logic          vec_valid;
  logic          svc_done = 1'b0;
  logic          vec_timeout;
  logic          timeout_clr = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // priorities: src0=1, src1=3, src2=1, src3=2
  prio_irq_ctrl #(
    .NUM_SRC    (NS),
    .PRIO_W     (2),
    .VEC_W      (8),
    .STACK_DEPTH(2),
    .TIMEOUT_CYC(16),
    .SRC_PRIO   ({2'd2, 2'd1, 2'd3, 2'd1})
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .src_req      (src_req),
    .nmi_req      (nmi_req),
    .core_irq     (core_irq),
    .core_ack     (core_ack),
    .src_ack      (src_ack),
    .dev_vec      (dev_vec),
    .dev_vec_valid(dev_vec_valid),
    .vec_out      (vec_out),
    .vec_valid    (vec_valid),
    .svc_done     (svc_done),
    .vec_timeout  (vec_timeout),
    .timeout_clr  (timeout_clr)
  );

  // {request mask, expected winner index}
  localparam logic [7:0] TV [7] = '{8'h10, 8'h50, 8'h42, 8'hD3, 8'hF1, 8'hA1, 8'h83};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_svc();
    svc_done = 1'b1;
    cyc(1);
    svc_done = 1'b0;
    cyc(1);
  endtask

  // Called at a negedge with core_irq expected high. Serves source idx.
  task automatic serve(input int idx, input logic [7:0] v);
    chk("R3 irq raised", 32'(core_irq), 32'd1);
    core_ack = 1'b1;
    cyc(1);
    core_ack = 1'b0;
    chk("R5 src_ack winner (R2/R4)", 32'(src_ack), 32'(1) << idx);
    chk("R5 irq dropped", 32'(core_irq), 32'd0);
    dev_vec = v;
    dev_vec_valid = 1'b1;
    if (idx < NS) src_req[idx] = 1'b0;
    else nmi_req = 1'b0;
    cyc(1);
    dev_vec_valid = 1'b0;
    chk("R5 src_ack one cycle", 32'(src_ack), 32'd0);
    chk("R6 vec_valid", 32'(vec_valid), 32'd1);
    chk("R6 vec_out", 32'(vec_out), 32'(v));
    cyc(1);
    chk("R6 vec_valid single", 32'(vec_valid), 32'd0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 irq", 32'(core_irq), 32'd0);
    chk("R1 src_ack", 32'(src_ack), 32'd0);
    chk("R1 vec_valid", 32'(vec_valid), 32'd0);
    chk("R1 vec_timeout", 32'(vec_timeout), 32'd0);

    // R10: stray acknowledge
    core_ack = 1'b1;
    cyc(1);
    core_ack = 1'b0;
    chk("R10 no ack", 32'(src_ack), 32'd0);
    cyc(1);
    chk("R10 no irq", 32'(core_irq), 32'd0);

    // R2 table walk
    for (int k = 0; k < 7; k++) begin
      src_req = TV[k][7:4];
      cyc(1);
      serve(int'(TV[k][3:0]), 8'hA0 + 8'(k));
      src_req = '0;
      end_svc();
    end

    // R3: equal level masked, R8 released by end-of-service
    src_req = 4'b0001;
    cyc(1);
    serve(0, 8'h11);
    src_req[2] = 1'b1;
    cyc(4);
    chk("R3 equal masked", 32'(core_irq), 32'd0);
    svc_done = 1'b1;
    cyc(1);
    svc_done = 1'b0;
    cyc(1);
    chk("R8 released after pop", 32'(core_irq), 32'd1);
    serve(2, 8'h22);
    end_svc();

    // R8 nesting, R3 lower masked, R9 full stack
    src_req = 4'b0001;
    cyc(1);
    serve(0, 8'h31);
    src_req[3] = 1'b1;
    cyc(1);
    chk("R8 nested higher", 32'(core_irq), 32'd1);
    serve(3, 8'h33);
    src_req[1] = 1'b1;
    cyc(4);
    chk("R9 full blocks", 32'(core_irq), 32'd0);
    svc_done = 1'b1;
    cyc(1);
    svc_done = 1'b0;
    cyc(1);
    chk("R9 resumes after pop", 32'(core_irq), 32'd1);
    serve(1, 8'h34);
    end_svc();
    end_svc();

    // R4 non-maskable over top device level, R3 lower masked
    src_req = 4'b0010;
    cyc(1);
    serve(1, 8'h41);
    src_req[0] = 1'b1;
    cyc(3);
    chk("R3 lower masked", 32'(core_irq), 32'd0);
    nmi_req = 1'b1;
    cyc(2);
    chk("R4 nmi presented", 32'(core_irq), 32'd1);
    serve(NS, 8'h5E);
    src_req = '0;
    end_svc();
    end_svc();

    // R7 timeout
    src_req = 4'b0001;
    cyc(1);
    chk("R7 irq before ack", 32'(core_irq), 32'd1);
    core_ack = 1'b1;
    cyc(1);
    core_ack = 1'b0;
    cyc(15);
    chk("R7 not yet expired", 32'(vec_timeout), 32'd0);
    cyc(1);
    chk("R7 expired", 32'(vec_timeout), 32'd1);
    chk("R7 no vector", 32'(vec_valid), 32'd0);
    cyc(1);
    chk("R7 level removed", 32'(core_irq), 32'd1);
    src_req = '0;
    cyc(4);
    chk("R7 sticky", 32'(vec_timeout), 32'd1);
    chk("R7 withdrawn request drops irq", 32'(core_irq), 32'd0);
    timeout_clr = 1'b1;
    cyc(1);
    timeout_clr = 1'b0;
    chk("R7 cleared", 32'(vec_timeout), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule